// File: doc/BRIEF.md
# Sigma-Delta ADC Conversion Engine

This block is the digital half of a first-order sigma-delta converter. An external comparator level arrives on `din`. The block passes it through a two-flop synchronizer and returns its registered inverse on `fb_out`, so that an outside RC integrator closes the loop. A free-running accumulator adds a fixed increment on every clock where the synchronized level is high. The accumulator is never cleared after reset.

A conversion measures a window of 2^n − 1 clocks, where n is the selected resolution. At the opening edge the block stores the negated accumulator. At the closing edge it adds the live accumulator to that stored value. The result is therefore the number of high clocks in the window, taken modulo the accumulator width. The window opens a fixed number of clocks after the start command, so its alignment is deterministic.

A one-shot input decides, at each window close, whether the engine halts or opens the next window on the same edge. With the channel-count parameter set to two, two independent accumulators share one window and return two results.

Top module: `sdadc_engine`

## Requirements
- R1: The inverted level of `din[c]` sampled at clock edge k appears on `fb_out[c]` after edge k+2. While reset is held, `fb_out` is all ones.
- R2: After reset, `busy` and `done` are 0 and every result field is 0.
- R3: For a window that opens at edge Es and lasts L clocks, the result of channel c equals the number of edges k in Es−2 … Es+L−3 at which `din[c]` was sampled high. The result changes only on an edge that also raises `done`.
- R4: If `start` is sampled high at edge E0 while idle, the window opens at edge E0+16. `done` is high for the one cycle after edge E0+16+L.
- R5: The window length L is 2^n − 1 clocks, where n is the value of `res_sel` sampled together with `start`, for every n from 1 to 16.
- R6: A `res_sel` value of 0, or a value above 16, selects n = 16 (L = 65535).
- R7: If `one_shot` is 1 at the closing edge, `busy` falls on that same edge and no further `done` follows. `busy` never falls except together with a `done`.
- R8: If `one_shot` is 0 at the closing edge, the next window opens on that same edge with the same L. Successive windows are contiguous, and each one produces its own `done` and result.
- R9: A `start` pulse while `busy` is high has no effect on window timing, length or result.
- R10: With two channels, each result field (channel c at bits c·W upward, W = accumulator width) counts only its own `din[c]` over the shared window.
- R11: All accumulation is modulo 2^W. A window whose count reaches or crosses an accumulator wrap still reports the exact count modulo 2^W.
- R12: `busy` rises only on the edge after an accepted `start`, and `done` is only raised while the engine was busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request a conversion (taken only when idle) |
| res_sel | input | RES_W | Resolution n; 0 or above MAX_RES means MAX_RES |
| one_shot | input | 1 | 1: halt after the current window; 0: keep converting |
| din | input | NUM_CH | Comparator levels, one per channel |
| fb_out | output | NUM_CH | Registered inverse of the synchronized levels |
| busy | output | 1 | Conversion sequence in progress |
| done | output | 1 | One-cycle pulse when a window closes |
| result | output | NUM_CH*ACC_W | Window counts, channel c at [c*ACC_W +: ACC_W] |

## Verification
The bench builds the engine with two channels and a 10-bit accumulator, keeping the 16-clock lead and the 16-bit resolution ceiling. The narrow accumulator wraps many times during the run, and the full-scale window at n = 10 (1023 clocks, all high) lands just below the wrap, so the modulo arithmetic is exercised constantly. Every resolution from 1 to 10 is swept in one-shot mode. Both clamp cases (0 and 20) run the full 65535-clock window. A run of contiguous continuous-mode windows is also checked. Each expected count is summed in the bench from its own record of the levels it drove.

// File: rtl/sdadc_pkg.sv
package sdadc_pkg;
  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_LEAD = 2'd1,
    SQ_WIN  = 2'd2
  } sq_state_e;
endpackage

// File: rtl/sdadc_front.sv
// Per-channel input synchronizer and feedback driver.
module sdadc_front #(
  parameter int NUM_CH = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_CH-1:0] din,
  output logic [NUM_CH-1:0] smp,
  output logic [NUM_CH-1:0] fb
);
  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic meta_q, smp_q, fb_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        meta_q <= 1'b0;
        smp_q  <= 1'b0;
        fb_q   <= 1'b1;
      end else begin
        meta_q <= din[c];
        smp_q  <= meta_q;
        fb_q   <= ~smp_q;
      end
    end
    assign smp[c] = smp_q;
    assign fb[c]  = fb_q;
  end
endmodule

// File: rtl/sdadc_accum.sv
// Free-running accumulator with window snapshot arithmetic.
module sdadc_accum #(
  parameter int ACC_W = 32,
  parameter int INC   = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hit,
  input  logic             open_win,
  input  logic             close_win,
  output logic [ACC_W-1:0] res
);
  localparam logic [ACC_W-1:0] INC_V = ACC_W'(INC);

  logic [ACC_W-1:0] acc_q;
  logic [ACC_W-1:0] base_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q  <= '0;
      base_q <= '0;
      res    <= '0;
    end else begin
      if (hit)       acc_q  <= acc_q + INC_V;
      if (open_win)  base_q <= '0 - acc_q;
      // close uses the previous base even when a new window opens on this edge
      if (close_win) res    <= base_q + acc_q;
    end
  end
endmodule

// File: rtl/sdadc_seq.sv
// Window sequencer: fixed lead, 2^n-1 window, one-shot or continuous.
module sdadc_seq
  import sdadc_pkg::*;
#(
  parameter int MAX_RES = 16,
  parameter int RES_W   = 5,
  parameter int LEAD    = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [RES_W-1:0] res_sel,
  input  logic             one_shot,
  output logic             busy,
  output logic             done,
  output logic             open_win,
  output logic             close_win
);
  localparam int LW = $clog2(LEAD + 1);
  localparam logic [RES_W-1:0] RES_MAX_V = RES_W'(MAX_RES);

  sq_state_e            state_q;
  logic [LW-1:0]        lcnt_q;
  logic [MAX_RES-1:0]   wcnt_q;
  logic [MAX_RES-1:0]   len_q;
  logic [RES_W-1:0]     n_eff;
  logic [MAX_RES:0]     pow2;
  logic [MAX_RES-1:0]   len_calc;
  logic                 lead_last;
  logic                 win_last;

  always_comb begin
    n_eff    = (res_sel == '0 || res_sel > RES_MAX_V) ? RES_MAX_V : res_sel;
    pow2     = (MAX_RES+1)'(1) << n_eff;
    len_calc = MAX_RES'(pow2 - (MAX_RES+1)'(1));
  end

  assign lead_last = (state_q == SQ_LEAD) && (lcnt_q == LW'(1));
  assign win_last  = (state_q == SQ_WIN) && (wcnt_q == '0);
  assign open_win  = lead_last || (win_last && !one_shot);
  assign close_win = win_last;
  assign busy      = (state_q != SQ_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= SQ_IDLE;
      lcnt_q  <= '0;
      wcnt_q  <= '0;
      len_q   <= '0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state_q)
        SQ_IDLE: begin
          if (start) begin
            len_q   <= len_calc;
            lcnt_q  <= LW'(LEAD);
            state_q <= SQ_LEAD;
          end
        end
        SQ_LEAD: begin
          lcnt_q <= lcnt_q - LW'(1);
          if (lead_last) begin
            wcnt_q  <= len_q - MAX_RES'(1);
            state_q <= SQ_WIN;
          end
        end
        SQ_WIN: begin
          wcnt_q <= wcnt_q - MAX_RES'(1);
          if (win_last) begin
            done <= 1'b1;
            if (one_shot) state_q <= SQ_IDLE;
            else          wcnt_q  <= len_q - MAX_RES'(1);
          end
        end
        default: state_q <= SQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sdadc_engine.sv
module sdadc_engine #(
  parameter int NUM_CH  = 1,
  parameter int ACC_W   = 32,
  parameter int INC     = 1,
  parameter int MAX_RES = 16,
  parameter int RES_W   = 5,
  parameter int LEAD    = 16
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      start,
  input  logic [RES_W-1:0]          res_sel,
  input  logic                      one_shot,
  input  logic [NUM_CH-1:0]         din,
  output logic [NUM_CH-1:0]         fb_out,
  output logic                      busy,
  output logic                      done,
  output logic [NUM_CH*ACC_W-1:0]   result
);
  logic [NUM_CH-1:0] smp;
  logic              open_win;
  logic              close_win;

  sdadc_front #(.NUM_CH(NUM_CH)) u_front (
    .clk (clk),
    .rst (rst),
    .din (din),
    .smp (smp),
    .fb  (fb_out)
  );

  sdadc_seq #(.MAX_RES(MAX_RES), .RES_W(RES_W), .LEAD(LEAD)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .res_sel   (res_sel),
    .one_shot  (one_shot),
    .busy      (busy),
    .done      (done),
    .open_win  (open_win),
    .close_win (close_win)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_acc
    sdadc_accum #(.ACC_W(ACC_W), .INC(INC)) u_accum (
      .clk       (clk),
      .rst       (rst),
      .hit       (smp[c]),
      .open_win  (open_win),
      .close_win (close_win),
      .res       (result[c*ACC_W +: ACC_W])
    );
  end
endmodule

// File: rtl/sdadc_engine_chk.sv
module sdadc_engine_chk #(
  parameter int NUM_CH = 1,
  parameter int ACC_W  = 32
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    start,
  input logic [NUM_CH-1:0]       din,
  input logic [NUM_CH-1:0]       fb_out,
  input logic                    busy,
  input logic                    done,
  input logic [NUM_CH*ACC_W-1:0] result
);
  logic [1:0] age_q;
  always_ff @(posedge clk) begin
    if (rst)                age_q <= 2'd0;
    else if (age_q != 2'd3) age_q <= age_q + 2'd1;
  end

  p_fb_inverse_r1: assert property (@(posedge clk) disable iff (rst)
    (age_q == 2'd3) |-> (fb_out == ~$past(din, 3)));

  p_result_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (age_q != 2'd0 && !done) |-> $stable(result));

  p_busy_fall_r7: assert property (@(posedge clk) disable iff (rst)
    (age_q != 2'd0 && $fell(busy)) |-> done);

  p_busy_rise_r12: assert property (@(posedge clk) disable iff (rst)
    (age_q != 2'd0 && $rose(busy)) |-> $past(start));

  p_done_busy_r12: assert property (@(posedge clk) disable iff (rst)
    (age_q != 2'd0 && done) |-> $past(busy));
endmodule

bind sdadc_engine sdadc_engine_chk #(.NUM_CH(NUM_CH), .ACC_W(ACC_W)) u_chk (
  .clk    (clk),
  .rst    (rst),
  .start  (start),
  .din    (din),
  .fb_out (fb_out),
  .busy   (busy),
  .done   (done),
  .result (result)
);

// File: tb/test_sdadc_engine.sv
module test_sdadc_engine;
  localparam int NCH = 2;
  localparam int AW  = 10;
  localparam int HMAX = 200000;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           start = 1'b0;
  logic [4:0]     res_sel = 5'd0;
  logic           one_shot = 1'b1;
  logic [NCH-1:0] din = '0;
  logic [NCH-1:0] fb_out;
  logic           busy, done;
  logic [NCH*AW-1:0] result;

  int  total = 0;
  int  bad = 0;
  int  cyc = 0;
  int  pat = 0;
  bit  h0 [0:HMAX-1];
  bit  h1 [0:HMAX-1];

  always #10 clk = ~clk;

  sdadc_engine #(.NUM_CH(NCH), .ACC_W(AW), .INC(1), .MAX_RES(16), .RES_W(5), .LEAD(16))
  i_sdadc_engine (
    .clk(clk), .rst(rst), .start(start), .res_sel(res_sel), .one_shot(one_shot),
    .din(din), .fb_out(fb_out), .busy(busy), .done(done), .result(result)
  );

  function automatic bit pat_bit(int sel, int ch, int k);
    case (sel)
      0: return (ch == 0);
      1: return (ch == 0) ? (k % 3 == 0) : (k % 5 < 2);
      2: return (ch == 0) ? ((k * 13) % 7 < 3) : (((k >> 2) ^ k) & 1) != 0;
      default: return (ch == 1);
    endcase
  endfunction

  always @(posedge clk) begin
    if (cyc < HMAX) begin
      h0[cyc] = din[0];
      h1[cyc] = din[1];
    end
    cyc = cyc + 1;
  end

  always @(negedge clk) begin
    din[0] <= pat_bit(pat, 0, cyc);
    din[1] <= pat_bit(pat, 1, cyc);
  end

  function automatic int exp_cnt(int ch, int lo, int hi);
    int s = 0;
    for (int k = lo; k <= hi; k++) s += (ch == 0) ? int'(h0[k]) : int'(h1[k]);
    return s % (1 << AW);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at cyc=%0d", req, act, expv, cyc);
    end
  endtask

  task automatic wait_to(input int t);
    while (cyc < t) @(negedge clk);
  endtask

  // Run nwin windows of length len; the last one closes with one_shot set.
  task automatic run_conv(input int rsel, input int len, input int nwin, input string req);
    int e0, es, ew;
    @(negedge clk);
    e0 = cyc;
    res_sel  = 5'(rsel);
    one_shot = (nwin == 1);
    start    = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R12 busy after start", int'(busy), 1);
    for (int w = 0; w < nwin; w++) begin
      es = e0 + 16 + w * len;
      ew = es + len;
      if (w == 0 && len >= 15) begin
        // R9: a start while busy must be ignored
        wait_to(es + 5);
        res_sel = 5'd1;
        start   = 1'b1;
        @(negedge clk);
        start   = 1'b0;
        res_sel = 5'(rsel);
      end
      wait_to(ew);
      chk(done == 1'b0, {req, " R4 done early"}, int'(done), 0);
      if (w == nwin - 1) one_shot = 1'b1;
      @(negedge clk);
      chk(done == 1'b1, {req, " R4/R5 done timing"}, int'(done), 1);
      for (int c = 0; c < NCH; c++)
        chk(int'(result[c*AW +: AW]) == exp_cnt(c, es - 2, es + len - 3),
            {req, " R3/R10/R11 count"}, int'(result[c*AW +: AW]), exp_cnt(c, es - 2, es + len - 3));
      if (w == nwin - 1)
        chk(busy == 1'b0, {req, " R7 busy after last"}, int'(busy), 0);
      else
        chk(busy == 1'b1, {req, " R8 busy continues"}, int'(busy), 1);
    end
    @(negedge clk);
    chk(done == 1'b0, {req, " R7 no further done"}, int'(done), 0);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL R4 watchdog actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R2 reset state
    chk(busy == 1'b0, "R2 busy", int'(busy), 0);
    chk(done == 1'b0, "R2 done", int'(done), 0);
    chk(result == '0, "R2 result", int'(result), 0);
    chk(fb_out == 2'b11, "R1 fb after reset", int'(fb_out), 3);

    // R1 feedback latency and polarity
    pat = 2;
    repeat (6) @(negedge clk);
    for (int i = 0; i < 24; i++) begin
      chk(fb_out[0] == ~h0[cyc-3], "R1 fb ch0", int'(fb_out[0]), int'(~h0[cyc-3]));
      chk(fb_out[1] == ~h1[cyc-3], "R1 fb ch1", int'(fb_out[1]), int'(~h1[cyc-3]));
      @(negedge clk);
    end

    // R5 one-shot sweep over resolutions, R9 mid-window starts, R11 wrap
    for (int n = 1; n <= 10; n++) begin
      pat = n % 4;
      run_conv(n, (1 << n) - 1, 1, "R5 sweep");
    end
    pat = 0;
    run_conv(10, 1023, 1, "R11 full scale");

    // R8 continuous contiguous windows
    pat = 1;
    run_conv(3, 7, 4, "R8 continuous");
    pat = 2;
    run_conv(4, 15, 3, "R8 continuous");

    // R6 clamp of out-of-range resolution
    pat = 2;
    run_conv(0, 65535, 1, "R6 clamp zero");
    pat = 1;
    run_conv(20, 65535, 1, "R6 clamp high");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule